// File: doc/BRIEF.md
# Chip-Select Decoder for a 64 KB Bus with a Split Top Quarter

This block turns the upper address lines of an 8-bit processor bus, together with the bus phase clock and the read/write line, into active-low chip selects. The 64 KB space is divided into four 16 KB quarters. The lower three quarters each enable one RAM bank. The top quarter is divided unevenly. Its first 2 KB is an I/O window that is fanned out to eight device slots of 256 bytes each. The rest of its lower 8 KB is a 6 KB ROM. Its upper 8 KB is a second ROM.

Device selects fire only while the phase clock is high, so no device sees a strobe while the address is still settling. ROM selects are given only on reads. A write that lands in either ROM range enables nothing and instead produces a one-clock flag. All outputs are registered: the decode of the inputs sampled at one rising clock edge appears just after that edge and holds until the next.

Only bits A15..A8 reach the block. The low address byte never affects a select.

Top module: `cs_decoder`

## Requirements
- R1: While `rst` is high at a rising edge, every select output is driven high (deasserted) after that edge, and `rom_wr_flag` is driven to 0.
- R2: For A15:A14 = 00, 01 or 10, `ram_sel_n[A15:A14]` is low and the other two bits are high. This holds for any phase and any read/write value. For A15:A14 = 11, all three bits are high.
- R3: For an address in 0xC000–0xC7FF (A15..A11 = 11000) with `phi2` high, `dev_sel_n[A10:A8]` is low and the other seven bits are high. For any address outside that window, all eight bits are high.
- R4: When `phi2` is low, all eight bits of `dev_sel_n` are high, whatever the address.
- R5: `rom_lo_sel_n` is low exactly when the address is in 0xC800–0xDFFF and `rw` is 1 (read).
- R6: `rom_hi_sel_n` is low exactly when the address is in 0xE000–0xFFFF and `rw` is 1 (read).
- R7: A write (`rw` = 0) into 0xC800–0xFFFF leaves both ROM selects high. `rom_wr_flag` is 1 for one clock when the sampled inputs first form such a write, meaning the inputs at the previous edge did not. In every other case it is 0.
- R8: At most one region is active at a time. The regions are the three RAM banks, the I/O group (any `dev_sel_n` bit low), the low ROM and the high ROM. Exactly one is active when `phi2` is high and the access is not a write into ROM.
- R9: Each output reflects the inputs sampled at the most recent rising edge: a latency of exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; inputs are sampled and outputs updated on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr_hi | input | 8 | Address bits A15..A8 |
| rw | input | 1 | 1 = read cycle, 0 = write cycle |
| phi2 | input | 1 | Bus phase clock; high marks the data phase |
| ram_sel_n | output | 3 | Active-low RAM bank selects, one bit per 16 KB bank |
| dev_sel_n | output | 8 | Active-low I/O device selects, 256 bytes each |
| rom_lo_sel_n | output | 1 | Active-low select for the 6 KB ROM at 0xC800–0xDFFF |
| rom_hi_sel_n | output | 1 | Active-low select for the 8 KB ROM at 0xE000–0xFFFF |
| rom_wr_flag | output | 1 | One-clock pulse marking a write into ROM space |

## Verification
The bench first walks all 65536 addresses as reads and then as writes, with the phase high. It compares every output against plain range comparisons. The reads separate the uneven split of the top quarter, in particular the 0xC7FF/0xC800 and 0xDFFF/0xE000 boundaries. The writes show that both ROMs go quiet while the RAM and I/O selects do not change. Because the write sweep crosses ROM space as one unbroken run, it also shows that the flag pulses only on entry. A second, sparse pass holds the phase low and alternates read and write on every step. This separates phase gating of the device selects from the RAM decode, which ignores the phase, and makes the flag pulse again on each new ROM write.

// File: rtl/cs_map_pkg.sv
package cs_map_pkg;
  // Bus geometry shared by the decoder and its sub-blocks
  localparam int unsigned DEC_W    = 8;  // address bits seen by the decoder
  localparam int unsigned SLOT_W   = 3;  // bits picking an I/O slot
  localparam int unsigned RAM_BANK = 3;  // quarters given to RAM

  typedef struct packed {
    logic [RAM_BANK-1:0] ram;
    logic                io;
    logic                rom_lo;
    logic                rom_hi;
  } region_t;
endpackage

// File: rtl/cs_quarter_decode.sv
module cs_quarter_decode #(
  parameter int unsigned RAM_BANK = 3
) (
  input  logic [1:0]          quarter,
  input  logic                half_bit,
  output logic [RAM_BANK-1:0] ram_hit,
  output logic                top_lo,
  output logic                top_hi
);
  logic top_q;

  for (genvar i = 0; i < RAM_BANK; i++) begin : g_ram
    assign ram_hit[i] = (quarter == 2'(i));
  end

  assign top_q  = &quarter;
  assign top_lo = top_q & ~half_bit;
  assign top_hi = top_q &  half_bit;
endmodule

// File: rtl/cs_window_decode.sv
module cs_window_decode #(
  parameter int unsigned SLOT_W = 3,
  localparam int unsigned SLOTS = 1 << SLOT_W
) (
  input  logic              en,
  input  logic [1:0]        sub,
  input  logic [SLOT_W-1:0] slot,
  output logic              io_hit,
  output logic [SLOTS-1:0]  dev_hit,
  output logic              rom_hit
);
  // The first quarter of the enabled 8 KB half is I/O; the rest is ROM
  assign io_hit  = en & (sub == 2'b00);
  assign rom_hit = en & (sub != 2'b00);

  for (genvar s = 0; s < SLOTS; s++) begin : g_dev
    assign dev_hit[s] = io_hit & (slot == SLOT_W'(s));
  end
endmodule

// File: rtl/cs_decoder.sv
module cs_decoder
  import cs_map_pkg::*;
#(
  parameter int unsigned ADDR_HI_W = DEC_W,
  parameter int unsigned DEV_SEL_W = SLOT_W,
  localparam int unsigned DEVS     = 1 << DEV_SEL_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_HI_W-1:0] addr_hi,
  input  logic                 rw,
  input  logic                 phi2,
  output logic [RAM_BANK-1:0]  ram_sel_n,
  output logic [DEVS-1:0]      dev_sel_n,
  output logic                 rom_lo_sel_n,
  output logic                 rom_hi_sel_n,
  output logic                 rom_wr_flag
);
  localparam int unsigned TOP = ADDR_HI_W - 1;

  logic [RAM_BANK-1:0] ram_hit;
  logic                top_lo, top_hi;
  logic                io_hit, rom_lo_hit;
  logic [DEVS-1:0]     dev_hit;
  region_t             nxt;
  logic                wr_rom, wr_rom_q;

  cs_quarter_decode #(.RAM_BANK(RAM_BANK)) u_quarter (
    .quarter (addr_hi[TOP -: 2]),
    .half_bit(addr_hi[TOP-2]),
    .ram_hit (ram_hit),
    .top_lo  (top_lo),
    .top_hi  (top_hi)
  );

  cs_window_decode #(.SLOT_W(DEV_SEL_W)) u_window (
    .en     (top_lo),
    .sub    (addr_hi[TOP-3 -: 2]),
    .slot   (addr_hi[TOP-5 -: DEV_SEL_W]),
    .io_hit (io_hit),
    .dev_hit(dev_hit),
    .rom_hit(rom_lo_hit)
  );

  // Qualification: devices by phase, ROMs by read
  always_comb begin
    nxt.ram    = ram_hit;
    nxt.io     = io_hit & phi2;
    nxt.rom_lo = rom_lo_hit & rw;
    nxt.rom_hi = top_hi & rw;
    wr_rom     = ~rw & (rom_lo_hit | top_hi);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_sel_n    <= '1;
      dev_sel_n    <= '1;
      rom_lo_sel_n <= 1'b1;
      rom_hi_sel_n <= 1'b1;
      rom_wr_flag  <= 1'b0;
      wr_rom_q     <= 1'b0;
    end else begin
      ram_sel_n    <= ~nxt.ram;
      dev_sel_n    <= nxt.io ? ~dev_hit : '1;
      rom_lo_sel_n <= ~nxt.rom_lo;
      rom_hi_sel_n <= ~nxt.rom_hi;
      rom_wr_flag  <= wr_rom & ~wr_rom_q;
      wr_rom_q     <= wr_rom;
    end
  end

  // ---------------- assertions ----------------
  logic [RAM_BANK+2:0] active_vec;
  assign active_vec = {~ram_sel_n, ~&dev_sel_n, ~rom_lo_sel_n, ~rom_hi_sel_n};

  assert_region_excl_R8: assert property (@(posedge clk) disable iff (rst)
    $countones(active_vec) <= 1);

  assert_dev_phase_R4: assert property (@(posedge clk) disable iff (rst)
    !phi2 |=> &dev_sel_n);

  assert_dev_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~dev_sel_n));

  assert_rom_write_R7: assert property (@(posedge clk) disable iff (rst)
    !rw |=> (rom_lo_sel_n && rom_hi_sel_n));

  assert_flag_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    rom_wr_flag |=> !rom_wr_flag);

  assert_ram_phase_free_R2: assert property (@(posedge clk) disable iff (rst)
    (addr_hi[TOP -: 2] == 2'b00) |=> !ram_sel_n[0]);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (&ram_sel_n && &dev_sel_n && rom_lo_sel_n && rom_hi_sel_n && !rom_wr_flag));
endmodule

// File: tb/sim_cs_decoder.sv
`timescale 1ns/1ps
module sim_cs_decoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] addr_hi = '0;
  logic       rw = 1'b1;
  logic       phi2 = 1'b1;
  logic [2:0] ram_sel_n;
  logic [7:0] dev_sel_n;
  logic       rom_lo_sel_n, rom_hi_sel_n, rom_wr_flag;

  always #4 clk = ~clk;  // 125 MHz

  cs_decoder u0 (
    .clk(clk), .rst(rst), .addr_hi(addr_hi), .rw(rw), .phi2(phi2),
    .ram_sel_n(ram_sel_n), .dev_sel_n(dev_sel_n),
    .rom_lo_sel_n(rom_lo_sel_n), .rom_hi_sel_n(rom_hi_sel_n),
    .rom_wr_flag(rom_wr_flag)
  );

  typedef struct {
    realtime    t;
    logic [15:0] a;
    logic [2:0] ram;
    logic [7:0] dev;
    logic       lo, hi, flag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  logic prev_wr = 1'b0;
  bit   done = 1'b0;

  task automatic chk(input string req, input int act, input int exp, input logic [15:0] a);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, a, act, exp);
    end
  endtask

  // Driver: computes expected outputs from address ranges
  task automatic drive(input logic [15:0] a, input logic r, input logic p);
    exp_t e;
    logic cur_wr;
    @(posedge clk);
    #2;
    addr_hi = a[15:8];
    rw = r;
    phi2 = p;
    e.t = $realtime;
    e.a = a;
    e.ram = 3'b111;
    if (a < 16'h4000)      e.ram = 3'b110;
    else if (a < 16'h8000) e.ram = 3'b101;
    else if (a < 16'hC000) e.ram = 3'b011;
    e.dev = 8'hFF;
    if (a >= 16'hC000 && a < 16'hC800 && p)
      e.dev[(a - 16'hC000) >> 8] = 1'b0;
    e.lo = !(a >= 16'hC800 && a < 16'hE000 && r);
    e.hi = !(a >= 16'hE000 && r);
    cur_wr = !r && a >= 16'hC800;
    e.flag = cur_wr && !prev_wr;
    prev_wr = cur_wr;
    q.push_back(e);
  endtask

  // Monitor: compares once a rising edge has registered the item (R9)
  always @(posedge clk) begin
    #4;
    while (q.size() > 0 && q[0].t + 6 <= $realtime) begin
      exp_t e;
      e = q.pop_front();
      chk("R2/R9 ram", int'(ram_sel_n), int'(e.ram), e.a);
      chk(e.dev != 8'hFF ? "R3" : (phi2 ? "R3 idle" : "R4"), int'(dev_sel_n), int'(e.dev), e.a);
      chk("R5", int'(rom_lo_sel_n), int'(e.lo), e.a);
      chk("R6", int'(rom_hi_sel_n), int'(e.hi), e.a);
      chk("R7 flag", int'(rom_wr_flag), int'(e.flag), e.a);
      // R8: region count against the requirement
      chk("R8", $countones({~ram_sel_n, ~&dev_sel_n, ~rom_lo_sel_n, ~rom_hi_sel_n}),
          $countones({~e.ram, ~&e.dev, ~e.lo, ~e.hi}), e.a);
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R1 ram", int'(ram_sel_n), 7, 16'h0);
    chk("R1 dev", int'(dev_sel_n), 255, 16'h0);
    chk("R1 rom", int'({rom_lo_sel_n, rom_hi_sel_n, rom_wr_flag}), 6, 16'h0);
    rst = 1'b0;
    for (int a = 0; a < 65536; a++) drive(16'(a), 1'b1, 1'b1);
    for (int a = 0; a < 65536; a++) drive(16'(a), 1'b0, 1'b1);
    for (int a = 0; a < 65536; a += 64) drive(16'(a), a[6], 1'b0);
    repeat (3) @(posedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected=done", cyc);
    end
    #1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule